// File: doc/BRIEF.md
# Field-Rate Counter-Divider with Hysteretic Vertical Lock

This block sits behind a sync slicer in a raster receiver. It runs on a clock at twice the line rate and sees a clean digital sliced vertical sync pulse. It also takes a flag that says the line loop is in lock and a flag that says a transmitter is present. It divides its clock by two to give the line-rate drive. A modulo-625 counter sets the field timing, and a short coincidence window sits around count zero.

Each rising edge of the incoming vertical pulse is tested against that window. A lock tracker decides where the vertical output comes from. In divider mode the output comes from the counter. In pass-through mode the output follows the incoming pulse.

The tracker has hysteresis so that a damaged field signal does not upset a stable picture. It leaves divider mode only after a long run of misses. It returns only when a seventh pulse, counted after a realignment, lands inside the window. Losing line lock sends the block to pass-through mode at once. A gate that blanks the line phase detector is open around the field interval, but only while divider mode is active. The vertical output is silenced whenever no transmitter is present.

Top module: `vsync_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters pass-through mode (`direct_mode`=1), clears the counter, the miss count and the pulse count, and drives `line_drive` low.
- R2: `line_drive` toggles on every clock edge after reset, so its period is 2 clocks.
- R3: The field counter counts 0 to 624 and wraps. In divider mode, `vsync_out` is high exactly while the count is 0 to 4, so the output period is 625 clocks whatever the input does.
- R4: A pulse event is a rising edge of `vsync_in`. It coincides when the count at that edge is 624, 0 or 1. In divider mode, up to 15 consecutive non-coinciding events keep divider mode. The 16th moves the block to pass-through mode and realigns the counter, so that the count is 1 on the clock after the event.
- R5: In pass-through mode with line lock, events are counted from the last realignment. On the 7th event, the block returns to divider mode if that event coincides. Otherwise the counter is realigned and counting restarts.
- R6: While `line_locked` is low, the block is in pass-through mode from the next clock on. Every event realigns the counter. When lock returns, R5 decides the mode.
- R7: In pass-through mode, `vsync_out` equals `vsync_in` in the same cycle when `tx_present` is high.
- R8: `vsync_out` is low in every cycle in which `tx_present` is low.
- R9: `flutter_gate` is high only in divider mode, and only while the count is 615 to 624 or 0 to 19.
- R10: In divider mode, a coinciding event clears the run of misses, so that 15 misses, one hit and then 15 more misses leave divider mode in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the line rate |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_in | input | 1 | Sliced vertical sync, active high |
| line_locked | input | 1 | High while the line loop is in lock |
| tx_present | input | 1 | High while a transmitter is detected |
| line_drive | output | 1 | Line-rate drive, the clock divided by two |
| vsync_out | output | 1 | Vertical sync output |
| direct_mode | output | 1 | 1 = pass-through, 0 = divider mode |
| flutter_gate | output | 1 | Blanking gate for the line phase detector |

## Verification
The bench targets the miss-run boundary: 15 misses must keep divider mode and the 16th must leave it. A tracker that counts one too few or one too many would drop lock early or hold it too long. It also checks that a single hit in the middle of a run clears the count, since a design that only saturates would unlock on scattered misses. During reacquisition the bench places a non-coinciding 7th pulse and then a coinciding one. A design that tests the wrong pulse, or does not realign, would either lock onto a foreign phase or never recover. Line-lock drops, a muted transmitter and random pulse phases round this out, with every output compared each cycle against a reference model built from the requirements.

// File: rtl/vdiv_pkg.sv
// Shared types for the field-rate divider.
package vdiv_pkg;
    // Where the vertical output is sourced from.
    typedef enum logic {
        MODE_DIVIDER = 1'b0,
        MODE_PASS    = 1'b1
    } vmode_t;
endpackage

// File: rtl/vdiv_counter.sv
// Field counter: counts modulo PERIOD on a clock at twice the line rate.
// It decodes the coincidence window, the output pulse phase and the
// flutter gate phase. A realign request loads 1, so that the event cycle
// itself counts as zero.
// Assumes: resync is a single-cycle request.
module vdiv_counter #(
    parameter int PERIOD  = 625,
    parameter int WIN     = 3,
    parameter int VS_LEN  = 5,
    parameter int FL_PRE  = 10,
    parameter int FL_POST = 20,
    localparam int CW     = $clog2(PERIOD),
    localparam int HALF   = WIN / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          resync,
    output logic [CW-1:0] cnt,
    output logic          in_win,
    output logic          vs_phase,
    output logic          gate_phase
);
    // Advance, wrap or realign the field count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (resync)
            cnt <= CW'(1);
        else if (cnt == CW'(PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    // Decode the window and phase intervals from the count.
    always_comb begin
        in_win     = (cnt >= CW'(PERIOD - HALF)) || (cnt <= CW'(HALF));
        vs_phase   = (cnt < CW'(VS_LEN));
        gate_phase = (cnt >= CW'(PERIOD - FL_PRE)) || (cnt < CW'(FL_POST));
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(PERIOD)); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!resync && cnt == CW'(PERIOD - 1)) |=> cnt == '0); // R3
    AST_CNT_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> in_win); // R4
endmodule

// File: rtl/vdiv_lock.sv
// Lock tracker: chooses between divider and pass-through sourcing.
// In divider mode it counts consecutive misses. In pass-through mode it
// counts events since the last realignment. Loss of line lock forces
// pass-through mode.
// Assumes: ev is a single-cycle rising-edge strobe.
module vdiv_lock
    import vdiv_pkg::*;
#(
    parameter int MISS_LIM = 16,
    parameter int REACQ    = 7,
    localparam int MW      = $clog2(MISS_LIM),
    localparam int PW      = $clog2(REACQ)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic in_win,
    input  logic line_locked,
    output logic direct,
    output logic resync
);
    vmode_t        mode, mode_n;
    logic [MW-1:0] miss, miss_n;
    logic [PW-1:0] pcnt, pcnt_n;

    // Next-state rules for mode, miss run and reacquisition count.
    always_comb begin
        mode_n = mode;
        miss_n = miss;
        pcnt_n = pcnt;
        resync = 1'b0;
        if (!line_locked) begin
            mode_n = MODE_PASS;
            miss_n = '0;
            pcnt_n = '0;
            resync = ev;
        end else if (mode == MODE_DIVIDER) begin
            if (ev) begin
                if (in_win) begin
                    miss_n = '0;
                end else if (miss == MW'(MISS_LIM - 1)) begin
                    mode_n = MODE_PASS;
                    miss_n = '0;
                    pcnt_n = '0;
                    resync = 1'b1;
                end else begin
                    miss_n = miss + MW'(1);
                end
            end
        end else if (ev) begin
            if (pcnt == PW'(REACQ - 1)) begin
                pcnt_n = '0;
                if (in_win) begin
                    mode_n = MODE_DIVIDER;
                    miss_n = '0;
                end else begin
                    resync = 1'b1;
                end
            end else begin
                pcnt_n = pcnt + PW'(1);
            end
        end
    end

    // Register the tracker state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_PASS;
            miss <= '0;
            pcnt <= '0;
        end else begin
            mode <= mode_n;
            miss <= miss_n;
            pcnt <= pcnt_n;
        end
    end

    assign direct = (mode == MODE_PASS);

    AST_UNLOCK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !line_locked |=> direct); // R6
    AST_REACQ_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (direct && !(ev && in_win && line_locked)) |=> direct); // R5
    AST_ENTER_PASS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && line_locked && !ev) |=> !direct); // R4
endmodule

// File: rtl/vsync_divider.sv
// Top level: detects the vertical sync edge, divides the clock for the
// line drive, and selects and gates the vertical output.
// Assumes: vsync_in is synchronous to clk and free of glitches.
module vsync_divider #(
    parameter int PERIOD   = 625,
    parameter int WIN      = 3,
    parameter int VS_LEN   = 5,
    parameter int FL_PRE   = 10,
    parameter int FL_POST  = 20,
    parameter int MISS_LIM = 16,
    parameter int REACQ    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    input  logic line_locked,
    input  logic tx_present,
    output logic line_drive,
    output logic vsync_out,
    output logic direct_mode,
    output logic flutter_gate
);
    localparam int CW = $clog2(PERIOD);

    logic          vs_q, ev, resync, in_win, vs_phase, gate_phase;
    logic [CW-1:0] cnt;

    // Keep the previous sync level and toggle the line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q       <= 1'b0;
            line_drive <= 1'b0;
        end else begin
            vs_q       <= vsync_in;
            line_drive <= ~line_drive;
        end
    end

    assign ev = vsync_in & ~vs_q;

    vdiv_counter #(
        .PERIOD(PERIOD), .WIN(WIN), .VS_LEN(VS_LEN),
        .FL_PRE(FL_PRE), .FL_POST(FL_POST)
    ) i_counter (
        .clk(clk), .rst_n(rst_n), .resync(resync), .cnt(cnt),
        .in_win(in_win), .vs_phase(vs_phase), .gate_phase(gate_phase)
    );

    vdiv_lock #(
        .MISS_LIM(MISS_LIM), .REACQ(REACQ)
    ) i_lock (
        .clk(clk), .rst_n(rst_n), .ev(ev), .in_win(in_win),
        .line_locked(line_locked), .direct(direct_mode), .resync(resync)
    );

    // Select the output source, gate it, and decode the flutter gate.
    always_comb begin
        vsync_out    = tx_present & (direct_mode ? vsync_in : vs_phase);
        flutter_gate = ~direct_mode & gate_phase;
    end

    AST_TX_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_present |-> !vsync_out); // R8
    AST_GATE_PASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |-> !flutter_gate); // R9
    AST_LINE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> line_drive != $past(line_drive)); // R2
    AST_CNT_UNUSED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode && vsync_out) |-> (cnt < CW'(VS_LEN))); // R3
endmodule

// File: tb/test_vsync_divider.sv
module test_vsync_divider;
    logic clk = 1'b0;
    logic rst_n, vs_in, ll_in, tx_in;
    logic line_drive, vsync_out, direct_mode, flutter_gate;
    int   n_chk = 0, n_bad = 0, n_cyc = 0;

    // Reference model state, built from the requirements.
    int   m_cnt, m_miss, m_pc;
    logic m_dir, m_vq, m_line;

    always #10 clk = ~clk;

    vsync_divider i_vsync_divider (
        .clk(clk), .rst_n(rst_n), .vsync_in(vs_in), .line_locked(ll_in),
        .tx_present(tx_in), .line_drive(line_drive), .vsync_out(vsync_out),
        .direct_mode(direct_mode), .flutter_gate(flutter_gate)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_vs(input logic v, input logic tx);
        return tx & (m_dir ? v : (m_cnt < 5));
    endfunction

    function automatic logic exp_gate();
        return !m_dir && (m_cnt >= 615 || m_cnt < 20);
    endfunction

    // Advance the model by one clock edge.
    task automatic step(input logic v, input logic ll);
        logic ev, coin, rs;
        ev = v & ~m_vq;
        coin = (m_cnt >= 624) || (m_cnt <= 1);
        rs = 1'b0;
        if (!rst_n) begin
            m_cnt = 0; m_miss = 0; m_pc = 0; m_dir = 1; m_vq = 0; m_line = 0;
            return;
        end
        if (!ll) begin
            m_dir = 1; m_pc = 0; m_miss = 0; rs = ev;
        end else if (!m_dir) begin
            if (ev) begin
                if (coin) m_miss = 0;
                else if (m_miss == 15) begin
                    m_dir = 1; m_pc = 0; m_miss = 0; rs = 1;
                end else m_miss++;
            end
        end else if (ev) begin
            if (m_pc == 6) begin
                m_pc = 0;
                if (coin) begin m_dir = 0; m_miss = 0; end
                else rs = 1;
            end else m_pc++;
        end
        m_cnt = rs ? 1 : (m_cnt == 624 ? 0 : m_cnt + 1);
        m_vq = v;
        m_line = ~m_line;
    endtask

    // Drive one cycle, compare all outputs, then advance the model.
    task automatic cyc(input logic v, input logic ll, input logic tx);
        @(negedge clk);
        vs_in = v; ll_in = ll; tx_in = tx;
        #1;
        if (rst_n) begin
            chk("R2 line_drive", line_drive, m_line);
            chk("R3 R7 R8 vsync_out", vsync_out, exp_vs(v, tx));
            chk("R4 R5 R6 direct_mode", direct_mode, m_dir);
            chk("R9 flutter_gate", flutter_gate, exp_gate());
        end
        step(v, ll);
        n_cyc++;
    endtask

    // Wait until the model count reaches tgt, then send a 4-cycle pulse.
    task automatic pulse_at(input int tgt, input logic ll, input logic tx);
        cyc(1'b0, ll, tx);
        while (m_cnt != tgt) cyc(1'b0, ll, tx);
        repeat (4) cyc(1'b1, ll, tx);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 1'b0; vs_in = 1'b0; ll_in = 1'b1; tx_in = 1'b1;
        repeat (3) cyc(1'b0, 1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset direct_mode", direct_mode, 1'b1);
        chk("R1 reset line_drive", line_drive, 1'b0);
        chk("R1 reset flutter_gate", flutter_gate, 1'b0);
        step(1'b0, 1'b1);
        // R5: a non-coinciding 7th pulse realigns and stays in pass-through
        repeat (7) pulse_at(300, 1'b1, 1'b1);
        chk("R5 off-window 7th stays pass", direct_mode, 1'b1);
        repeat (6) pulse_at(0, 1'b1, 1'b1);
        chk("R5 before 7th still pass", direct_mode, 1'b1);
        pulse_at(0, 1'b1, 1'b1);
        chk("R5 coinciding 7th reacquires", direct_mode, 1'b0);
        // R3: divider output free-runs with no input pulses
        repeat (1300) cyc(1'b0, 1'b1, 1'b1);
        // R10: 15 misses, a hit, 15 misses keep divider mode
        repeat (15) pulse_at(300, 1'b1, 1'b1);
        chk("R4 fifteen misses hold", direct_mode, 1'b0);
        pulse_at(0, 1'b1, 1'b1);
        repeat (15) pulse_at(300, 1'b1, 1'b1);
        chk("R10 hit clears run", direct_mode, 1'b0);
        pulse_at(300, 1'b1, 1'b1);
        chk("R4 sixteenth miss enters pass", direct_mode, 1'b1);
        // R7: pass-through follows the input
        cyc(1'b1, 1'b1, 1'b1);
        chk("R7 pass follows input", vsync_out, 1'b1);
        cyc(1'b0, 1'b1, 1'b1);
        repeat (7) pulse_at(0, 1'b1, 1'b1);
        chk("R5 reacquire after unlock", direct_mode, 1'b0);
        // R8: transmitter absent silences the output
        repeat (700) cyc(1'b0, 1'b1, 1'b0);
        // R6: line-lock loss forces pass-through, then recovers
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R6 unlock forces pass", direct_mode, 1'b1);
        repeat (3) pulse_at(200, 1'b0, 1'b1);
        repeat (7) pulse_at(0, 1'b1, 1'b1);
        chk("R6 lock return obeys reacquire", direct_mode, 1'b0);
        // Random phases, lock drops and transmitter gaps
        for (int i = 0; i < 50; i++) begin
            int   r, tgt;
            logic ll, tx;
            r   = $urandom % 10;
            tgt = (r < 7) ? 0 : int'($urandom % 625);
            ll  = ($urandom % 12) != 0;
            tx  = ($urandom % 8) != 0;
            pulse_at(tgt, ll, tx);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule